// File: doc/BRIEF.md
# Multi-rate GMII/MII Transmit Adapter

This block turns a MAC-side byte stream into the transmit side of a GMII or MII port. A 3-bit speed code selects the transfer width. At the two gigabit rates, each accepted byte goes out in full on the 8-bit data bus in a single clock. At 10 and 100 Mbps, each byte is sent as two 4-bit transfers on the low bits of the bus, and the upstream ready line drops for the second transfer. The block drives the transmit enable and error lines. Between frames, the error line can also carry a carrier-extension code or a low-power idle code.

The block runs on the single transmit clock that is supplied to it. A one-cycle software reset request produces an active-low reset output, synchronized to that clock and three cycles long. For the length of that pulse the adapter is flushed. A speed code change is picked up only while no frame is in flight. A frame therefore never switches width partway through.

Top module: `multirate_tx_adapter`

## Requirements
- R1: Speed codes 3'b010 (2.5 Gbps) and 3'b011 (1 Gbps) select byte mode. Codes 3'b100 (100 Mbps) and 3'b111 (10 Mbps) select nibble mode. Every other code selects byte mode.
- R2: In byte mode `inReady` is high outside a reset pulse. A byte accepted at a clock edge appears in full on `txData` right after that edge, with `txEn` high.
- R3: In nibble mode an accepted byte is sent over two consecutive cycles. The first cycle carries data bits [3:0] and the second carries bits [7:4], both on `txData[3:0]` with `txData[7:4]` at zero. `inReady` is low during the first of those two cycles.
- R4: `txEn` is high in exactly the cycles whose `txData` carries accepted stream data, and low otherwise.
- R5: A byte accepted with `inErr` high drives `txErr` high, together with `txEn`, in every transfer cycle of that byte. Otherwise `txErr` is low while `txEn` is high.
- R6: In an idle cycle with `lpiReq` high, and with no carrier extension selected, the outputs are `txEn`=0, `txErr`=1 and `txData`=8'h01.
- R7: In an idle cycle in byte mode with `extReq` high, the outputs are `txEn`=0, `txErr`=1 and `txData`=8'h0F, whatever the value of `lpiReq`. In nibble mode `extReq` has no effect.
- R8: The transfer mode is reloaded from `speedCode` only at an edge with no frame in progress, no pending high nibble and no byte accepted. A frame begins with an accepted byte and ends with an accepted byte that has `inLast` high.
- R9: A `swRstReq` sampled high at an edge drives `txRstN` low for exactly the next three cycles. During those cycles `inReady`, `txEn` and `txErr` are low and any pending nibble is dropped. `inReady` is also low while `swRstReq` is high.
- R10: While `rstN` is low, `txData`, `txEn`, `txErr` and `txRstN` are all zero. `txRstN` rises at the first edge after `rstN` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| swRstReq | input | 1 | Software reset request, sampled per cycle |
| speedCode | input | 3 | Link speed selection code |
| extReq | input | 1 | Signal carrier extension while idle (byte mode) |
| lpiReq | input | 1 | Signal low-power idle while idle |
| inValid | input | 1 | Upstream byte valid |
| inReady | output | 1 | Adapter can accept a byte this cycle |
| inData | input | 8 | Upstream byte |
| inLast | input | 1 | Byte is the final one of its frame |
| inErr | input | 1 | Byte is to be sent with the error line raised |
| txData | output | 8 | PHY-facing transmit data |
| txEn | output | 1 | Transmit enable |
| txErr | output | 1 | Transmit error / extension / low-power line |
| txRstN | output | 1 | Synchronized active-low reset pulse output |

## Verification
The hardest situations to reach are a speed code change while a frame is in flight and a software reset that lands between the two halves of a nibble transfer. To reach the first, the bench opens a frame in byte mode, switches the code to a nibble rate, and keeps sending bytes. It checks that they still leave whole and that the new width applies only after one idle cycle. To reach the second, the bench raises the reset request in the cycle that shows a low nibble. It checks that the high nibble never appears, that the stream is held off for exactly three cycles, and that a byte held valid across the pulse is accepted only afterwards.

// File: rtl/txa_pkg.sv
package txa_pkg;

  typedef enum logic {
    XFER_BYTE   = 1'b0,
    XFER_NIBBLE = 1'b1
  } xferMode_e;

  localparam logic [2:0] SPD_2G5  = 3'b010;
  localparam logic [2:0] SPD_1G   = 3'b011;
  localparam logic [2:0] SPD_100M = 3'b100;
  localparam logic [2:0] SPD_10M  = 3'b111;

  localparam logic [7:0] LPI_CODE = 8'h01;
  localparam logic [7:0] EXT_CODE = 8'h0F;

  typedef struct packed {
    logic clear;
    logic loadByte;
    logic loadLow;
    logic loadHigh;
    logic idleExt;
    logic idleLpi;
  } ctrlStrobes_t;

  function automatic xferMode_e decodeSpeed(input logic [2:0] code);
    case (code)
      SPD_100M, SPD_10M: decodeSpeed = XFER_NIBBLE;
      SPD_2G5, SPD_1G:   decodeSpeed = XFER_BYTE;
      default:           decodeSpeed = XFER_BYTE;
    endcase
  endfunction

endpackage

// File: rtl/txa_rst_pulse.sv
module txa_rst_pulse #(
  parameter int PULSE_CYCLES = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqIn,
  output logic rstOutN,
  output logic busy
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain  <= '0;
      rstOutN <= 1'b0;
    end else if (reqIn) begin
      remain  <= CNT_W'(PULSE_CYCLES - 1);
      rstOutN <= 1'b0;
    end else if (remain != '0) begin
      remain  <= remain - 1'b1;
    end else begin
      rstOutN <= 1'b1;
    end
  end

  assign busy = !rstOutN;

  // R9: once the pulse starts it holds for at least two further cycles
  p_rst_width_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstOutN) |=> !rstOutN ##1 !rstOutN);

endmodule

// File: rtl/txa_ctrl.sv
module txa_ctrl
  import txa_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         swRstReq,
  input  logic         rstBusy,
  input  logic [2:0]   speedCode,
  input  logic         extReq,
  input  logic         lpiReq,
  input  logic         inValid,
  input  logic         inLast,
  output logic         inReady,
  output ctrlStrobes_t strobes
);
  xferMode_e modeReg;
  logic      nibPend;
  logic      inFrame;
  logic      accept;
  logic      idle;

  assign inReady = !nibPend && !rstBusy && !swRstReq;
  assign accept  = inValid && inReady;
  assign idle    = !strobes.clear && !accept && !nibPend;

  always_comb begin
    strobes          = '0;
    strobes.clear    = swRstReq || rstBusy;
    strobes.loadByte = accept && (modeReg == XFER_BYTE);
    strobes.loadLow  = accept && (modeReg == XFER_NIBBLE);
    strobes.loadHigh = nibPend && !strobes.clear;
    strobes.idleExt  = idle && extReq && (modeReg == XFER_BYTE);
    strobes.idleLpi  = idle && lpiReq && !strobes.idleExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= XFER_BYTE;
      nibPend <= 1'b0;
      inFrame <= 1'b0;
    end else if (strobes.clear) begin
      modeReg <= decodeSpeed(speedCode);
      nibPend <= 1'b0;
      inFrame <= 1'b0;
    end else begin
      nibPend <= strobes.loadLow;
      if (accept) begin
        inFrame <= !inLast;
      end
      if (!inFrame && !nibPend && !accept) begin
        modeReg <= decodeSpeed(speedCode);
      end
    end
  end

  // R3: after a byte enters in nibble mode, the next cycle refuses input
  p_ready_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (accept && modeReg == XFER_NIBBLE) |=> !inReady);

  // R8: the mode holds while a frame or a half byte is in flight
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((inFrame || nibPend) && !strobes.clear) |=> $stable(modeReg));

  // R9: nothing is taken from upstream during a reset pulse
  p_no_accept_rst_r9: assert property (@(posedge clk) disable iff (!rstN)
    rstBusy |-> !inReady);

endmodule

// File: rtl/txa_datapath.sv
module txa_datapath
  import txa_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inErr,
  output logic [BYTE_W-1:0] txData,
  output logic              txEn,
  output logic              txErr
);
  localparam int NIB_W = BYTE_W / 2;

  logic [NIB_W-1:0] hiNib;
  logic             hiErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txData <= '0;
      txEn   <= 1'b0;
      txErr  <= 1'b0;
      hiNib  <= '0;
      hiErr  <= 1'b0;
    end else if (strobes.clear) begin
      txData <= '0;
      txEn   <= 1'b0;
      txErr  <= 1'b0;
      hiNib  <= '0;
      hiErr  <= 1'b0;
    end else if (strobes.loadByte) begin
      txData <= inData;
      txEn   <= 1'b1;
      txErr  <= inErr;
    end else if (strobes.loadLow) begin
      txData <= {{NIB_W{1'b0}}, inData[NIB_W-1:0]};
      txEn   <= 1'b1;
      txErr  <= inErr;
      hiNib  <= inData[BYTE_W-1:NIB_W];
      hiErr  <= inErr;
    end else if (strobes.loadHigh) begin
      txData <= {{NIB_W{1'b0}}, hiNib};
      txEn   <= 1'b1;
      txErr  <= hiErr;
    end else if (strobes.idleExt) begin
      txData <= BYTE_W'(EXT_CODE);
      txEn   <= 1'b0;
      txErr  <= 1'b1;
    end else if (strobes.idleLpi) begin
      txData <= BYTE_W'(LPI_CODE);
      txEn   <= 1'b0;
      txErr  <= 1'b1;
    end else begin
      txData <= '0;
      txEn   <= 1'b0;
      txErr  <= 1'b0;
    end
  end

  // R3: the second half of a byte is enabled and keeps the upper bits clear
  p_high_nib_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadHigh |=> (txEn && txData[BYTE_W-1:NIB_W] == '0));

  // R6 / R7: error without enable only ever carries an idle signalling code
  p_idle_code_r6: assert property (@(posedge clk) disable iff (!rstN)
    (txErr && !txEn) |-> (txData == BYTE_W'(LPI_CODE) || txData == BYTE_W'(EXT_CODE)));

  // R9: a flush leaves the line quiet
  p_clear_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (!txEn && !txErr));

endmodule

// File: rtl/multirate_tx_adapter.sv
module multirate_tx_adapter
  import txa_pkg::*;
#(
  parameter int BYTE_W       = 8,
  parameter int PULSE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swRstReq,
  input  logic [2:0]        speedCode,
  input  logic              extReq,
  input  logic              lpiReq,
  input  logic              inValid,
  output logic              inReady,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inLast,
  input  logic              inErr,
  output logic [BYTE_W-1:0] txData,
  output logic              txEn,
  output logic              txErr,
  output logic              txRstN
);
  ctrlStrobes_t strobes;
  logic         rstBusy;

  txa_rst_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) rst_pulse_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqIn   (swRstReq),
    .rstOutN (txRstN),
    .busy    (rstBusy)
  );

  txa_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .swRstReq  (swRstReq),
    .rstBusy   (rstBusy),
    .speedCode (speedCode),
    .extReq    (extReq),
    .lpiReq    (lpiReq),
    .inValid   (inValid),
    .inLast    (inLast),
    .inReady   (inReady),
    .strobes   (strobes)
  );

  txa_datapath #(.BYTE_W(BYTE_W)) datapath_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .inData  (inData),
    .inErr   (inErr),
    .txData  (txData),
    .txEn    (txEn),
    .txErr   (txErr)
  );

endmodule

// File: tb/multirate_tx_adapter_tb_top.sv
module multirate_tx_adapter_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       swRstReq = 1'b0;
  logic [2:0] speedCode = 3'b011;
  logic       extReq = 1'b0;
  logic       lpiReq = 1'b0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] inData = 8'h00;
  logic       inLast = 1'b0;
  logic       inErr = 1'b0;
  logic [7:0] txData;
  logic       txEn;
  logic       txErr;
  logic       txRstN;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  multirate_tx_adapter dut_i (
    .clk(clk), .rstN(rstN), .swRstReq(swRstReq), .speedCode(speedCode),
    .extReq(extReq), .lpiReq(lpiReq), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inLast(inLast), .inErr(inErr), .txData(txData),
    .txEn(txEn), .txErr(txErr), .txRstN(txRstN)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idleCycle(input string req);
    inValid = 1'b0;
    tick();
    check(req, "idle txEn", {7'b0, txEn}, 8'h00);
  endtask

  task automatic setSpeed(input logic [2:0] code);
    speedCode = code;
    inValid = 1'b0;
    tick();
  endtask

  task automatic sendByteMode(input string req, input logic [7:0] d,
                              input logic last, input logic err);
    inValid = 1'b1; inData = d; inLast = last; inErr = err;
    check("R2", "ready before byte", {7'b0, inReady}, 8'h01);
    tick();
    inValid = 1'b0;
    check(req, "byte data", txData, d);
    check("R4", "byte txEn", {7'b0, txEn}, 8'h01);
    check("R5", "byte txErr", {7'b0, txErr}, {7'b0, err});
  endtask

  task automatic sendNibbleMode(input string req, input logic [7:0] d,
                                input logic last, input logic err);
    inValid = 1'b1; inData = d; inLast = last; inErr = err;
    check(req, "ready before nibble", {7'b0, inReady}, 8'h01);
    tick();
    inValid = 1'b0;
    check(req, "low nibble", txData, {4'h0, d[3:0]});
    check("R4", "low txEn", {7'b0, txEn}, 8'h01);
    check("R5", "low txErr", {7'b0, txErr}, {7'b0, err});
    check("R3", "ready gap", {7'b0, inReady}, 8'h00);
    tick();
    check(req, "high nibble", txData, {4'h0, d[7:4]});
    check("R4", "high txEn", {7'b0, txEn}, 8'h01);
    check("R5", "high txErr", {7'b0, txErr}, {7'b0, err});
    check("R3", "ready back", {7'b0, inReady}, 8'h01);
  endtask

  task automatic t_reset();
    #1;
    check("R10", "rst txData", txData, 8'h00);
    check("R10", "rst txEn", {7'b0, txEn}, 8'h00);
    check("R10", "rst txErr", {7'b0, txErr}, 8'h00);
    check("R10", "rst txRstN", {7'b0, txRstN}, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    tick();
    check("R10", "txRstN after release", {7'b0, txRstN}, 8'h01);
    check("R10", "ready after release", {7'b0, inReady}, 8'h01);
  endtask

  task automatic t_byte_rates();
    setSpeed(3'b011);
    sendByteMode("R2", 8'hA5, 1'b0, 1'b0);
    sendByteMode("R2", 8'h3C, 1'b0, 1'b1);
    sendByteMode("R2", 8'hF0, 1'b1, 1'b0);
    idleCycle("R4");
    setSpeed(3'b010);
    sendByteMode("R1", 8'h5A, 1'b0, 1'b0);
    sendByteMode("R1", 8'hC3, 1'b1, 1'b0);
    idleCycle("R4");
  endtask

  task automatic t_nibble_rates();
    setSpeed(3'b100);
    sendNibbleMode("R3", 8'h9E, 1'b0, 1'b0);
    sendNibbleMode("R5", 8'h47, 1'b1, 1'b1);
    idleCycle("R4");
    setSpeed(3'b111);
    sendNibbleMode("R1", 8'hD2, 1'b1, 1'b0);
    idleCycle("R4");
  endtask

  task automatic t_unknown_codes();
    setSpeed(3'b000);
    sendByteMode("R1", 8'h81, 1'b1, 1'b0);
    idleCycle("R1");
    setSpeed(3'b101);
    sendByteMode("R1", 8'h7E, 1'b1, 1'b0);
    idleCycle("R1");
  endtask

  task automatic t_idle_codes();
    setSpeed(3'b011);
    lpiReq = 1'b1;
    tick();
    check("R6", "lpi data", txData, 8'h01);
    check("R6", "lpi err", {7'b0, txErr}, 8'h01);
    check("R6", "lpi en", {7'b0, txEn}, 8'h00);
    extReq = 1'b1;
    tick();
    check("R7", "ext over lpi data", txData, 8'h0F);
    check("R7", "ext err", {7'b0, txErr}, 8'h01);
    lpiReq = 1'b0;
    tick();
    check("R7", "ext data", txData, 8'h0F);
    check("R7", "ext en", {7'b0, txEn}, 8'h00);
    setSpeed(3'b100);
    tick();
    check("R7", "ext nibble data", txData, 8'h00);
    check("R7", "ext nibble err", {7'b0, txErr}, 8'h00);
    lpiReq = 1'b1;
    tick();
    check("R6", "lpi nibble data", txData, 8'h01);
    check("R6", "lpi nibble err", {7'b0, txErr}, 8'h01);
    extReq = 1'b0; lpiReq = 1'b0;
    tick();
    check("R6", "plain idle err", {7'b0, txErr}, 8'h00);
  endtask

  task automatic t_speed_change_mid_frame();
    setSpeed(3'b011);
    sendByteMode("R8", 8'h12, 1'b0, 1'b0);
    speedCode = 3'b100;
    sendByteMode("R8", 8'hB7, 1'b0, 1'b0);
    sendByteMode("R8", 8'hE9, 1'b1, 1'b0);
    idleCycle("R8");
    sendNibbleMode("R8", 8'h6C, 1'b1, 1'b0);
    idleCycle("R8");
  endtask

  task automatic t_sw_reset_mid_nibble();
    setSpeed(3'b100);
    inValid = 1'b1; inData = 8'hA9; inLast = 1'b0; inErr = 1'b0;
    tick();
    check("R3", "low before reset", txData, 8'h09);
    swRstReq = 1'b1;
    inData = 8'h55; inLast = 1'b1;
    check("R9", "ready with request", {7'b0, inReady}, 8'h00);
    for (int i = 0; i < 3; i++) begin
      tick();
      swRstReq = 1'b0;
      check("R9", "txRstN low", {7'b0, txRstN}, 8'h00);
      check("R9", "ready low", {7'b0, inReady}, 8'h00);
      check("R9", "txEn low", {7'b0, txEn}, 8'h00);
    end
    tick();
    check("R9", "txRstN back", {7'b0, txRstN}, 8'h01);
    check("R9", "nothing taken", {7'b0, txEn}, 8'h00);
    check("R9", "ready back", {7'b0, inReady}, 8'h01);
    tick();
    inValid = 1'b0;
    check("R9", "held byte low nibble", txData, 8'h05);
    check("R9", "held byte txEn", {7'b0, txEn}, 8'h01);
    tick();
    check("R9", "held byte high nibble", txData, 8'h05);
    idleCycle("R9");
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_byte_rates();
    t_nibble_rates();
    t_unknown_codes();
    t_idle_codes();
    t_speed_change_mid_frame();
    t_sw_reset_mid_nibble();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule